// File: doc/BRIEF.md
# Serial ADC Streaming Receiver

This block reads a set of serial analog-to-digital converters that stream samples without ever being sent a command. It drives one serial clock shared by every converter and one active-low chip-select line per converter. The chip-select is pulsed once per conversion frame, and the block shifts in each converter's data line on its own lane. A channel-select output alternates between two channels on successive frames, in the style of a left/right audio word clock.

Once `enable` is raised, the block runs frame after frame with no per-sample request from the host. At the end of each frame, every lane copies its finished sample into a holding register. That register carries the sample right-justified, the channel it belongs to and a sticky new-data flag. The host reads one word per converter and pulses a per-lane clear strobe to acknowledge it.

The serial clock is the system clock divided by an even integer. With the default divider of one and a 96 MHz system clock, the block produces a 48 MHz serial clock. A 16-period frame then gives 3 MSPS of 14-bit samples on each lane.

Top module: `adc_stream_rx`

## Requirements
- R1: `sclk` has a period of exactly 2*HALF_DIV system clock cycles with a 50 % duty cycle. It is low while idle and starts with a low half-period after `enable` rises.
- R2: A frame lasts FRAME_CLKS serial clock periods. All `cs_n` bits are high during the first period of each frame and low for the rest of it. `cs_n` falls on the same system clock edge as an `sclk` falling edge, and all converters share the same `cs_n` timing.
- R3: Rising `sclk` edges are numbered k = 1, 2, ... from the fall of `cs_n`. The bits sampled at edges k = SKIP_BITS+1 through SKIP_BITS+SAMPLE_W form the sample, MSB first. Bits at every other edge are ignored.
- R4: `chan_sel` is 0 during the first frame after enable and toggles at the end of every frame.
- R5: The lane word `result[i*RES_W +: RES_W]` holds these fields, where RES_W = SAMPLE_W+2:
  - bits [SAMPLE_W-1:0]: the sample.
  - bit SAMPLE_W: the channel tag, equal to the `chan_sel` value during the frame that produced the sample.
  - bit SAMPLE_W+1: the new-data flag.
  - All bits are 0 after reset.
- R6: The sample and tag fields change only at frame end, on the same system clock edge on which `cs_n` rises. All fields change together on that edge.
- R7: The new-data flag is set at each frame end. A one-cycle pulse on `rd_clr[i]` clears lane i's flag on the next edge. The pulse leaves that lane's sample and tag, and every other lane, unchanged.
- R8: If `rd_clr[i]` is high on the same edge as a frame end, the flag stays set and the new sample is loaded.
- R9: When `enable` is low, the next edge forces `sclk` low, all `cs_n` high and `chan_sel` to 0, and restarts frame timing. Result words keep their contents.
- R10: Each converter's data line feeds only its own lane, so different converters yield independent samples in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the free-running frame sequence while high |
| sdata | input | NUM_ADC | Serial data line from each converter |
| rd_clr | input | NUM_ADC | Per-lane pulse that clears the new-data flag after a host read |
| sclk | output | 1 | Shared serial clock |
| cs_n | output | NUM_ADC | Active-low chip-select per converter |
| chan_sel | output | 1 | Channel select, alternating per frame |
| result | output | NUM_ADC*(SAMPLE_W+2) | Latched result word for each lane |

## Verification
The bench builds the block with the following parameters:
- HALF_DIV = 2, so the divider counter actually counts instead of ticking every cycle.
- FRAME_CLKS = 18 with SAMPLE_W = 14 and SKIP_BITS = 1. This leaves both a dropped leading bit and two dropped trailing bits, and the converter model drives alternating junk on those bits so that an off-by-one capture window corrupts the sample.
- NUM_ADC = 2, with different data on the two lanes, which brings lane crosstalk and per-lane clearing within reach.

With the frame length known, the bench can place a clear strobe on the exact frame-end edge to exercise the set-over-clear priority.

// File: rtl/adc_stream_pkg.sv
package adc_stream_pkg;

  // Width of one lane's result word: sample, channel tag, new-data flag.
  function automatic int unsigned result_width(input int unsigned sample_w);
    return sample_w + 2;
  endfunction

  // A rising edge inside frame period 'pos' is edge number pos after cs_n fell.
  function automatic logic in_capture_window(input int unsigned pos,
                                             input int unsigned skip,
                                             input int unsigned width);
    return (pos >= skip + 1) && (pos <= skip + width);
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_DIV   = 1,
  parameter int unsigned FRAME_CLKS = 16,
  parameter int unsigned POS_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output logic             sclk,
  output logic [POS_W-1:0] pos,
  output logic             chan_sel,
  output logic             rise_ev,
  output logic             frame_done
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_CLKS - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic             fall_ev;

  assign tick       = (div_cnt == DIV_LAST);
  assign rise_ev    = enable && tick && !sclk;
  assign fall_ev    = enable && tick && sclk;
  assign frame_done = fall_ev && (pos == POS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sclk     <= 1'b0;
      pos      <= '0;
      chan_sel <= 1'b0;
    end else if (!enable) begin
      div_cnt  <= '0;
      sclk     <= 1'b0;
      pos      <= '0;
      chan_sel <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
      if (sclk) begin
        if (pos == POS_LAST) begin
          pos      <= '0;
          chan_sel <= ~chan_sel;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sclk && !chan_sel && pos == '0)); // R9

  AST_CHAN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (chan_sel != $past(chan_sel))); // R4

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !frame_done) |=> $stable(chan_sel)); // R4

endmodule

// File: rtl/adc_rx_lane.sv
module adc_rx_lane #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned RES_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             frame_done,
  input  logic             chan_tag,
  input  logic             sdata,
  input  logic             rd_clr,
  output logic [RES_W-1:0] result
);

  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] smp;
  logic                tag;
  logic                fresh;

  assign result = {fresh, tag, smp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (capture) begin
      shreg <= {shreg[SAMPLE_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp   <= '0;
      tag   <= 1'b0;
      fresh <= 1'b0;
    end else if (frame_done) begin
      smp   <= shreg;
      tag   <= chan_tag;
      fresh <= 1'b1;
    end else if (rd_clr) begin
      fresh <= 1'b0;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(result[SAMPLE_W:0])); // R6

  AST_NEW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> result[RES_W-1]); // R8

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !frame_done) |=> !result[RES_W-1]); // R7

endmodule

// File: rtl/adc_stream_rx.sv
module adc_stream_rx #(
  parameter int unsigned NUM_ADC    = 2,
  parameter int unsigned SAMPLE_W   = 14,
  parameter int unsigned FRAME_CLKS = 16,
  parameter int unsigned SKIP_BITS  = 1,
  parameter int unsigned HALF_DIV   = 1,
  localparam int unsigned RES_W     = adc_stream_pkg::result_width(SAMPLE_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [NUM_ADC-1:0]       sdata,
  input  logic [NUM_ADC-1:0]       rd_clr,
  output logic                     sclk,
  output logic [NUM_ADC-1:0]       cs_n,
  output logic                     chan_sel,
  output logic [NUM_ADC*RES_W-1:0] result
);

  localparam int unsigned POS_W = $clog2(FRAME_CLKS);

  logic [POS_W-1:0] pos;
  logic             rise_ev;
  logic             frame_done;
  logic             capture;

  adc_sclk_gen #(
    .HALF_DIV  (HALF_DIV),
    .FRAME_CLKS(FRAME_CLKS),
    .POS_W     (POS_W)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sclk      (sclk),
    .pos       (pos),
    .chan_sel  (chan_sel),
    .rise_ev   (rise_ev),
    .frame_done(frame_done)
  );

  assign cs_n    = {NUM_ADC{pos == '0}};
  assign capture = rise_ev &&
                   adc_stream_pkg::in_capture_window(32'(pos), SKIP_BITS, SAMPLE_W);

  for (genvar g = 0; g < NUM_ADC; g++) begin : g_lane
    adc_rx_lane #(
      .SAMPLE_W(SAMPLE_W),
      .RES_W   (RES_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .frame_done(frame_done),
      .chan_tag  (chan_sel),
      .sdata     (sdata[g]),
      .rd_clr    (rd_clr[g]),
      .result    (result[g*RES_W +: RES_W])
    );
  end

  AST_CS_FALL_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n[0]) |-> $fell(sclk)); // R2

  AST_CS_RISE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(cs_n[0])) |-> $past(frame_done)); // R6

  AST_CAPTURE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!cs_n[0] && !sclk)); // R3

endmodule

// File: tb/adc_stream_rx_tb_top.sv
`timescale 1ns/1ps
module adc_stream_rx_tb_top;

  localparam int NUM_ADC    = 2;
  localparam int SAMPLE_W   = 14;
  localparam int FRAME_CLKS = 18;
  localparam int SKIP_BITS  = 1;
  localparam int HALF_DIV   = 2;
  localparam int RES_W      = SAMPLE_W + 2;
  localparam int MASK       = (1 << SAMPLE_W) - 1;
  localparam int CLK_NS     = 10;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     enable;
  logic [NUM_ADC-1:0]       sdata;
  logic [NUM_ADC-1:0]       rd_clr;
  logic                     sclk;
  logic [NUM_ADC-1:0]       cs_n;
  logic                     chan_sel;
  logic [NUM_ADC*RES_W-1:0] result;

  int checks = 0;
  int fails  = 0;
  int fidx   = -1;
  int kedge  = 0;

  always #(CLK_NS/2) clk = ~clk;

  adc_stream_rx #(
    .NUM_ADC(NUM_ADC), .SAMPLE_W(SAMPLE_W), .FRAME_CLKS(FRAME_CLKS),
    .SKIP_BITS(SKIP_BITS), .HALF_DIV(HALF_DIV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sdata(sdata), .rd_clr(rd_clr),
    .sclk(sclk), .cs_n(cs_n), .chan_sel(chan_sel), .result(result)
  );

  function automatic int exp_sample(input int f, input int i);
    if (f < 0) return 0;
    if (f == 0) return (i == 0) ? MASK : 0;
    if (f == 1) return (i == 0) ? 'h2AAA : 'h1555;
    return ((f * 2651 + i * 9001) ^ (f << 5)) & MASK;
  endfunction

  function automatic logic adc_bit(input int f, input int i, input int k);
    if (k >= SKIP_BITS + 1 && k <= SKIP_BITS + SAMPLE_W)
      return logic'((exp_sample(f, i) >> (SAMPLE_W - 1 - (k - SKIP_BITS - 1))) & 1);
    return logic'((k + i) & 1);
  endfunction

  function automatic int smp_of(input int i);
    return int'(result[i*RES_W +: SAMPLE_W]);
  endfunction
  function automatic int tag_of(input int i);
    return int'(result[i*RES_W + SAMPLE_W]);
  endfunction
  function automatic int new_of(input int i);
    return int'(result[i*RES_W + SAMPLE_W + 1]);
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Converter model: shifts a new bit out after each serial clock falling edge.
  initial begin
    sdata = '0;
    forever begin
      @(negedge sclk);
      #1;
      if (cs_n[0]) kedge = 0;
      else kedge++;
      for (int i = 0; i < NUM_ADC; i++) sdata[i] = adc_bit(fidx, i, kedge);
    end
  end

  initial begin
    forever begin
      @(negedge cs_n[0]);
      fidx++;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; rd_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 sclk idle low", sclk, 0);
    chk("R9 cs_n idle high", cs_n, 2'b11);
    chk("R4 chan_sel idle", chan_sel, 0);
    chk("R5 result reset", result, 0);
  endtask

  task automatic t_stream(input int nfr);
    time t0, t1, tr, tf, tprev;
    int f;
    fidx = -1;
    @(negedge clk) enable = 1'b1;
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk("R1 sclk period", (t1 - t0) / CLK_NS, 2 * HALF_DIV);
    tprev = 0;
    for (int n = 0; n < nfr; n++) begin
      @(posedge cs_n[0]); tr = $time;
      #1;
      f = fidx;
      for (int i = 0; i < NUM_ADC; i++) begin
        chk("R3 R10 sample", smp_of(i), exp_sample(f, i));
        chk("R4 R5 channel tag", tag_of(i), f & 1);
        chk("R7 new flag at frame end", new_of(i), 1);
      end
      chk("R4 chan_sel toggled", chan_sel, (f + 1) & 1);
      @(negedge cs_n[0]); tf = $time;
      chk("R2 cs_n high one sclk period", (tf - tr) / CLK_NS, 2 * HALF_DIV);
      if (tprev != 0)
        chk("R2 frame length", (tf - tprev) / CLK_NS, FRAME_CLKS * 2 * HALF_DIV);
      tprev = tf;
      #1;
      chk("R2 cs_n low on all lanes", cs_n, 2'b00);
      chk("R2 sclk low at cs_n fall", sclk, 0);
      chk("R4 chan_sel in frame", chan_sel, fidx & 1);
    end
  endtask

  task automatic t_read_clear();
    int s0, s1;
    repeat (10) @(posedge clk);
    #1;
    s0 = smp_of(0); s1 = smp_of(1);
    rd_clr = 2'b01;
    @(posedge clk);
    #1;
    rd_clr = '0;
    chk("R7 lane0 flag cleared", new_of(0), 0);
    chk("R7 lane1 flag untouched", new_of(1), 1);
    chk("R7 lane0 sample kept", smp_of(0), s0);
    chk("R7 lane1 sample kept", smp_of(1), s1);
    @(posedge cs_n[0]);
    #1;
    chk("R7 lane0 flag set again", new_of(0), 1);
    chk("R6 lane0 next sample", smp_of(0), exp_sample(fidx, 0));
  endtask

  task automatic t_collide();
    int f;
    @(negedge cs_n[0]);
    f = fidx;
    repeat ((FRAME_CLKS - 1) * 2 * HALF_DIV - 1) @(posedge clk);
    #1;
    rd_clr = 2'b11;
    @(posedge clk);
    #1;
    rd_clr = '0;
    chk("R6 cs_n rises on latch edge", cs_n, 2'b11);
    for (int i = 0; i < NUM_ADC; i++) begin
      chk("R8 flag wins over clear", new_of(i), 1);
      chk("R8 R6 new sample loaded", smp_of(i), exp_sample(f, i));
    end
  endtask

  task automatic t_disable();
    logic [NUM_ADC*RES_W-1:0] snap;
    repeat (7) @(posedge clk);
    #1;
    snap = result;
    @(negedge clk) enable = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 sclk low on disable", sclk, 0);
    chk("R9 cs_n high on disable", cs_n, 2'b11);
    chk("R9 chan_sel cleared", chan_sel, 0);
    repeat (50) @(posedge clk);
    #1;
    chk("R9 result retained", result, snap);
    chk("R9 sclk stays low", sclk, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(5);
    t_read_clear();
    t_collide();
    t_disable();
    t_stream(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule